// File: doc/BRIEF.md
# Two-Word Memory-Increment Sequencer

This block is a small multi-cycle datapath steered by a hardwired step sequencer. It has a program counter, a memory address register, a memory buffer register, an instruction register, one eight-function ALU and a word-addressed internal memory. On each clock step the sequencer drives one fixed set of control points. These points choose the ALU's A operand (PC or MBR), give a 3-bit function code, and name the one register that captures the ALU result or the memory word.

Each instruction takes two consecutive memory words: an opcode word, then an operand-address word. The increment opcode reads the word at that operand address, adds one to it through the ALU and writes it back. It then returns to opcode fetch. Any other opcode stops the sequencer and raises a done flag.

A test harness puts a program into memory through a load port before the run and can write words during the run. It observes any memory word through a combinational peek port.

Top module: `incr_seq_top`

## Requirements
- R1: While `rst` is high at a rising edge, PC becomes 0, `done_o` and `wr_strobe_o` are 0 after that edge, and the memory contents are left unchanged. The first edge with `rst` low starts an opcode fetch at address 0.
- R2: An opcode word equal to 16'h0001 at address P, followed at P+1 by an operand word whose low ADDR_W bits give address A, replaces memory[A] with memory[A]+1. The instruction takes 11 edges. `wr_strobe_o` is high only during the cycle before the 11th edge, and memory[A] changes at that edge.
- R3: PC is incremented at the 2nd edge and at the 6th edge of an increment instruction, and it changes at no other time.
- R4: Any opcode word other than 16'h0001 halts the sequencer. `done_o` rises after the 5th edge of that instruction and then stays high. PC is left at the halt word's address plus one, and no further memory write occurs.
- R5: Incrementing the word 16'hFFFF stores 16'h0000.
- R6: The increment reads its target during the same instruction. An increment aimed at a later opcode word therefore changes what the sequencer executes when it reaches that word.
- R7: When `ld_en` is high, `ld_data` is written to `ld_addr` at the rising edge. This works during reset, during a run and after halt. If the sequencer writes back to the same address at the same edge, the sequencer's value is stored. `peek_data` always shows the word at `peek_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Harness memory write enable |
| ld_addr | input | ADDR_W | Harness write address |
| ld_data | input | DATA_W | Harness write data |
| peek_addr | input | ADDR_W | Observation read address |
| peek_data | output | DATA_W | Memory word at `peek_addr` (combinational) |
| pc_o | output | ADDR_W | Current program counter |
| done_o | output | 1 | Sequencer halted |
| wr_strobe_o | output | 1 | Write-back step in progress |

## Verification
The harness load port and the sequencer's write-back can both write memory at the same edge. The bench provokes this by driving a harness write to the address the first increment targets, at exactly its 11th edge. It then judges that the incremented value survives. A second harness write during the same run goes to an unrelated address, and that write must land. A behavioural per-cycle model applies the harness write first and the write-back second. It is compared with PC, done, the write strobe and a sweeping peek of memory on every clock.

// File: rtl/incr_seq_pkg.sv
package incr_seq_pkg;

    localparam int unsigned DEF_DATA_W = 16;
    localparam int unsigned DEF_ADDR_W = 6;
    localparam logic [15:0] OPC_INCR   = 16'h0001;

    typedef enum logic [2:0] {
        FN_ADD  = 3'b000,
        FN_PASS = 3'b001,
        FN_INC  = 3'b010,
        FN_SHL  = 3'b011,
        FN_SUB  = 3'b100,
        FN_NOT  = 3'b101,
        FN_DEC  = 3'b110,
        FN_SHR  = 3'b111
    } alu_fn_e;

    typedef enum logic {
        ASEL_PC  = 1'b0,
        ASEL_MBR = 1'b1
    } asel_e;

    typedef enum logic [3:0] {
        ST_F_MAR, ST_F_PC, ST_F_RD, ST_F_IR,
        ST_O_MAR, ST_O_PC, ST_O_RD, ST_O_ADR,
        ST_X_RD,  ST_X_INC, ST_X_WR, ST_HALT
    } step_e;

    typedef struct packed {
        asel_e   a_sel;
        alu_fn_e fn;
        logic    ld_mar;
        logic    ld_pc;
        logic    ld_ir;
        logic    ld_mbr;
        logic    mem_en;
        logic    mem_rd;
        logic    mem_wr;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{a_sel: ASEL_PC, fn: FN_PASS, default: 1'b0};

    function automatic step_e step_after(step_e s, logic is_incr);
        case (s)
            ST_O_MAR: return is_incr ? ST_O_PC : ST_HALT;
            ST_X_WR:  return ST_F_MAR;
            ST_HALT:  return ST_HALT;
            default:  return step_e'(s + 4'd1);
        endcase
    endfunction

endpackage

// File: rtl/incr_seq_alu.sv
module incr_seq_alu
    import incr_seq_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  alu_fn_e           fn,
    output logic [DATA_W-1:0] c
);
    always_comb begin
        case (fn)
            FN_ADD:  c = a + b;
            FN_PASS: c = a;
            FN_INC:  c = a + DATA_W'(1);
            FN_SHL:  c = a << 1;
            FN_SUB:  c = a - b;
            FN_NOT:  c = ~a;
            FN_DEC:  c = a - DATA_W'(1);
            default: c = a >> 1;
        endcase
    end
endmodule

// File: rtl/incr_seq_ctrl.sv
module incr_seq_ctrl
    import incr_seq_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] ir,
    output step_e             step_o,
    output ctrl_t             cp_o
);
    step_e step_q;
    logic  is_incr;

    assign is_incr = (ir == DATA_W'(OPC_INCR));
    assign step_o  = step_q;

    always_ff @(posedge clk) begin
        if (rst) step_q <= ST_F_MAR;
        else     step_q <= step_after(step_q, is_incr);
    end

    always_comb begin
        cp_o = CTRL_IDLE;
        case (step_q)
            ST_F_MAR, ST_O_MAR: begin
                if (step_q == ST_F_MAR || is_incr) begin
                    cp_o.a_sel  = ASEL_PC;
                    cp_o.fn     = FN_PASS;
                    cp_o.ld_mar = 1'b1;
                end
            end
            ST_F_PC, ST_O_PC: begin
                cp_o.a_sel = ASEL_PC;
                cp_o.fn    = FN_INC;
                cp_o.ld_pc = 1'b1;
            end
            ST_F_RD, ST_O_RD, ST_X_RD: begin
                cp_o.mem_en = 1'b1;
                cp_o.mem_rd = 1'b1;
                cp_o.ld_mbr = 1'b1;
            end
            ST_F_IR: begin
                cp_o.a_sel = ASEL_MBR;
                cp_o.fn    = FN_PASS;
                cp_o.ld_ir = 1'b1;
            end
            ST_O_ADR: begin
                cp_o.a_sel  = ASEL_MBR;
                cp_o.fn     = FN_PASS;
                cp_o.ld_mar = 1'b1;
            end
            ST_X_INC: begin
                cp_o.a_sel  = ASEL_MBR;
                cp_o.fn     = FN_INC;
                cp_o.ld_mbr = 1'b1;
            end
            ST_X_WR: begin
                cp_o.mem_en = 1'b1;
                cp_o.mem_wr = 1'b1;
            end
            default: cp_o = CTRL_IDLE;
        endcase
    end
endmodule

// File: rtl/incr_seq_mem.sv
module incr_seq_mem
    import incr_seq_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] pk_addr,
    output logic [DATA_W-1:0] pk_data
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    assign rd_data = words[rd_addr];
    assign pk_data = words[pk_addr];

    // harness write first, write-back last: on a shared address the sequencer value lands
    always_ff @(posedge clk) begin
        if (ld_en) words[ld_addr] <= ld_data;
        if (wr_en) words[wr_addr] <= wr_data;
    end
endmodule

// File: rtl/incr_seq_top.sv
module incr_seq_top
    import incr_seq_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [DATA_W-1:0] peek_data,
    output logic [ADDR_W-1:0] pc_o,
    output logic              done_o,
    output logic              wr_strobe_o
);
    localparam int unsigned PAD_W = DATA_W - ADDR_W;

    logic [ADDR_W-1:0] pc_q, mar_q;
    logic [DATA_W-1:0] mbr_q, ir_q;
    logic [DATA_W-1:0] alu_a, alu_c, mem_q;
    step_e             step;
    ctrl_t             cp;
    logic [3:0]        load_vec;

    incr_seq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .ir     (ir_q),
        .step_o (step),
        .cp_o   (cp)
    );

    assign alu_a = (cp.a_sel == ASEL_PC) ? {{PAD_W{1'b0}}, pc_q} : mbr_q;

    incr_seq_alu #(.DATA_W(DATA_W)) u_alu (
        .a  (alu_a),
        .b  (mbr_q),
        .fn (cp.fn),
        .c  (alu_c)
    );

    incr_seq_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .ld_en   (ld_en),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .wr_en   (cp.mem_en & cp.mem_wr),
        .wr_addr (mar_q),
        .wr_data (mbr_q),
        .rd_addr (mar_q),
        .rd_data (mem_q),
        .pk_addr (peek_addr),
        .pk_data (peek_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            mar_q <= '0;
            mbr_q <= '0;
            ir_q  <= '0;
        end else begin
            if (cp.ld_pc)  pc_q  <= alu_c[ADDR_W-1:0];
            if (cp.ld_mar) mar_q <= alu_c[ADDR_W-1:0];
            if (cp.ld_ir)  ir_q  <= alu_c;
            if (cp.ld_mbr) mbr_q <= (cp.mem_en & cp.mem_rd) ? mem_q : alu_c;
        end
    end

    assign load_vec    = {cp.ld_mar, cp.ld_pc, cp.ld_ir, cp.ld_mbr};
    assign pc_o        = pc_q;
    assign done_o      = (step == ST_HALT);
    assign wr_strobe_o = cp.mem_en & cp.mem_wr;
endmodule

// File: rtl/incr_seq_chk.sv
module incr_seq_chk #(
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] pc,
    input logic              done,
    input logic              wr,
    input logic [3:0]        loads,
    input logic              mem_en,
    input logic              mem_rd,
    input logic              mem_wr
);
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == '0 && !done && !wr));                      // R1

    AST_ONE_LOAD: assert property (@(posedge clk) disable iff (rst)
        $onehot0(loads));                                                // R2

    AST_MEM_STROBE: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> (mem_rd ^ mem_wr));                                   // R2

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wr |=> !wr);                                                     // R2

    AST_PC_PLUS_ONE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && (pc != $past(pc)) |-> (pc == $past(pc) + 1'b1));  // R3

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        done |=> (done && $stable(pc)));                                 // R4

    AST_HALT_NO_WR: assert property (@(posedge clk) disable iff (rst)
        done |-> !wr);                                                   // R4
endmodule

bind incr_seq_top incr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .pc     (pc_o),
    .done   (done_o),
    .wr     (wr_strobe_o),
    .loads  (load_vec),
    .mem_en (cp.mem_en),
    .mem_rd (cp.mem_rd),
    .mem_wr (cp.mem_wr)
);

// File: tb/sim_incr_seq_top.sv
module sim_incr_seq_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DW = 16;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;
    logic [AW-1:0] peek_addr = '0;
    logic [DW-1:0] peek_data;
    logic [AW-1:0] pc_o;
    logic          done_o;
    logic          wr_strobe_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;

    always #2.5ns clk = ~clk;

    incr_seq_top #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk         (clk),
        .rst         (rst),
        .ld_en       (ld_en),
        .ld_addr     (ld_addr),
        .ld_data     (ld_data),
        .peek_addr   (peek_addr),
        .peek_data   (peek_data),
        .pc_o        (pc_o),
        .done_o      (done_o),
        .wr_strobe_o (wr_strobe_o)
    );

    // behavioural reference: step 11 means halted
    int mpc = 0, mmar = 0, mmbr = 0, mir = 0, mstep = 0;
    int mmem [DEPTH];

    always @(posedge clk) begin
        int rdv;
        rdv = mmem[mmar];
        if (ld_en) mmem[ld_addr] = int'(ld_data);
        if (rst) begin
            mpc = 0; mmar = 0; mmbr = 0; mir = 0; mstep = 0;
        end else begin
            case (mstep)
                0:  begin mmar = mpc; mstep = 1; end
                1:  begin mpc = (mpc + 1) % DEPTH; mstep = 2; end
                2:  begin mmbr = rdv; mstep = 3; end
                3:  begin mir = mmbr; mstep = 4; end
                4:  begin
                        if (mir != 1) mstep = 11;
                        else begin mmar = mpc; mstep = 5; end
                    end
                5:  begin mpc = (mpc + 1) % DEPTH; mstep = 6; end
                6:  begin mmbr = rdv; mstep = 7; end
                7:  begin mmar = mmbr % DEPTH; mstep = 8; end
                8:  begin mmbr = rdv; mstep = 9; end
                9:  begin mmbr = (mmbr + 1) & 16'hFFFF; mstep = 10; end
                10: begin mmem[mmar] = mmbr; mstep = 0; end
                default: mstep = 11;
            endcase
        end
    end

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R3 pc per cycle", int'(pc_o), mpc);
            chk("R4 done per cycle", int'(done_o), int'(mstep == 11));
            chk("R2 write strobe per cycle", int'(wr_strobe_o), int'(mstep == 10));
            chk("R7 peek per cycle", int'(peek_data), mmem[peek_addr]);
        end
    end

    task automatic load_word(int a, int d);
        ld_en = 1'b1; ld_addr = AW'(a); ld_data = DW'(d);
        @(posedge clk); #1;
        ld_en = 1'b0;
    endtask

    task automatic peek_chk(string req, int a, int exp);
        peek_addr = AW'(a);
        #0.5;
        chk(req, int'(peek_data), exp);
    endtask

    // run until halted; k counts edges since reset release
    task automatic run_prog(int limit, bit inject);
        bit fin = 1'b0;
        for (int k = 0; k < limit && !fin; k++) begin
            peek_addr = AW'(k);
            ld_en = 1'b0;
            if (inject && k == 10) begin ld_en = 1'b1; ld_addr = 6'd32; ld_data = 16'h1234; end
            if (inject && k == 15) begin ld_en = 1'b1; ld_addr = 6'd40; ld_data = 16'hBEEF; end
            @(posedge clk); #1;
            if (done_o) fin = 1'b1;
        end
        ld_en = 1'b0;
        if (!fin) chk("R4 watchdog: run never halted", 0, 1);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mmem[i] = 0;
        @(posedge clk); #1;
        for (int i = 0; i < DEPTH; i++) load_word(i, 0);
        load_word(0, 16'h0001); load_word(1, 16'h0020);
        load_word(2, 16'h0001); load_word(3, 16'h0021);
        load_word(4, 16'h0001); load_word(5, 16'h0006);
        load_word(6, 16'h0000); load_word(7, 16'h0020);
        load_word(8, 16'h0003);
        load_word(32, 16'h0005); load_word(33, 16'hFFFF);
        cmp_on = 1'b1;
        #0.5;
        chk("R1 reset pc", int'(pc_o), 0);
        chk("R1 reset done", int'(done_o), 0);
        chk("R1 reset strobe", int'(wr_strobe_o), 0);
        peek_chk("R1 memory kept through reset", 33, 16'hFFFF);

        rst = 1'b0;
        run_prog(200, 1'b1);
        chk("R4 halt pc after word 8", int'(pc_o), 9);
        chk("R4 done raised", int'(done_o), 1);
        peek_chk("R2 R7 target incremented twice, harness write lost", 32, 16'h0007);
        peek_chk("R5 wrap to zero", 33, 16'h0000);
        peek_chk("R6 halt word rewritten to increment", 6, 16'h0001);
        peek_chk("R7 unrelated harness write landed", 40, 16'hBEEF);
        repeat (4) begin @(posedge clk); #1; end
        chk("R4 pc stays while halted", int'(pc_o), 9);
        load_word(41, 16'h00A5);
        peek_chk("R7 harness write after halt", 41, 16'h00A5);

        rst = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        chk("R1 second reset pc", int'(pc_o), 0);
        chk("R1 second reset done", int'(done_o), 0);
        peek_chk("R1 memory kept on second reset", 32, 16'h0007);

        rst = 1'b0;
        run_prog(200, 1'b0);
        chk("R4 halt on opcode 0002 at word 6", int'(pc_o), 7);
        peek_chk("R2 target after second run", 32, 16'h0008);
        peek_chk("R5 zero incremented to one", 33, 16'h0001);
        peek_chk("R6 word 6 incremented again", 6, 16'h0002);

        cmp_on = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200us;
        n_bad++;
        $display("FAIL R4 global watchdog expired: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule